// File: doc/BRIEF.md
# Memory-to-Memory Block Copy Engine

This engine copies a block of bytes from one memory area to another while it is master of a simple memory bus. One address register supplies the source and another supplies the destination. Each byte takes two bus accesses. A read strobe fetches the byte into an internal staging register, and a write strobe then stores that register at the destination. The engine runs only while its enable input is high. A software start pulse launches a transfer, and no external request line is involved.

The length is given as a terminal count N, and the engine moves N+1 bytes. A hold option freezes the source address, so one stored value is repeated over the whole destination area. Each address can count up or down. When the last write is done, the engine gives a one-cycle end pulse and returns to idle. The staging register keeps the last byte moved, and it stays readable on an output.

Top module: `dma_m2m_engine`

## Requirements
- R1: While `en` is 0, a `start` pulse is ignored: `busy`, `mem_rd` and `mem_wr` stay 0.
- R2: When `start` is 1 and `en` is 1 in idle, `src_base`, `dst_base`, `xfer_cnt`, `hold_src`, `src_dir` and `dst_dir` are latched. In the next cycle `mem_rd` is 1 with `mem_addr` equal to `src_base`.
- R3: Each byte uses three cycles: a read-strobe cycle, a capture cycle with no strobe, then a write-strobe cycle. `mem_rdata` is sampled one clock after the read strobe. The write cycle drives that byte on `mem_wdata`.
- R4: With `hold_src` 0, the source address changes by one after each byte. It increments when `src_dir` is 0 and decrements when `src_dir` is 1.
- R5: With `hold_src` 1, every read of the transfer uses `src_base`.
- R6: The destination address changes by one after each write. It increments when `dst_dir` is 0 and decrements when `dst_dir` is 1. The first write goes to `dst_base`.
- R7: A count of N moves N+1 bytes. In the cycle after the last write, `eop` is 1 for exactly one cycle and `busy` is 0.
- R8: After completion, `temp_q` holds the last byte moved until the next transfer captures a new byte.
- R9: `mem_rd` and `mem_wr` are never 1 together. A `start` pulse during a transfer is ignored.
- R10: After reset, `busy`, `mem_rd`, `mem_wr` and `eop` are 0 and `temp_q` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Engine enable |
| hold_src | input | 1 | 1 keeps the source address fixed (fill) |
| src_dir | input | 1 | Source step: 0 up, 1 down |
| dst_dir | input | 1 | Destination step: 0 up, 1 down |
| start | input | 1 | Software start pulse |
| src_base | input | AW | Initial source address |
| dst_base | input | AW | Initial destination address |
| xfer_cnt | input | CW | Terminal count (bytes minus one) |
| mem_addr | output | AW | Bus address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid one clock after the read strobe |
| eop | output | 1 | One-cycle end-of-transfer pulse |
| busy | output | 1 | Transfer in progress |
| temp_q | output | DW | Staging register contents |

## Verification
Assertions check on every cycle that the two strobes never overlap and that each write strobe follows a read strobe by exactly two cycles. They also check that the end pulse lasts one cycle and comes right after a write with the engine idle, that a held source address does not move, and that no read begins while the engine is disabled. Only the bench scenarios can show that the right addresses appear in both directions and that the byte count matches the terminal count. They also show that fills repeat one value and that the staging register keeps the last byte. These are checked against a behavioural per-cycle model and a shadow memory.

// File: rtl/dma_m2m_pkg.sv
package dma_m2m_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_CAP  = 2'd2,
    ST_WR   = 2'd3
  } seq_st_t;
endpackage

// File: rtl/dma_m2m_chan.sv
module dma_m2m_chan #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic          dir_in,
  input  logic          hold_in,
  input  logic          step,
  output logic [AW-1:0] addr_q
);
  logic dec_q;
  logic hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      dec_q  <= 1'b0;
      hold_q <= 1'b0;
    end else if (load) begin
      addr_q <= load_addr;
      dec_q  <= dir_in;
      hold_q <= hold_in;
    end else if (step && !hold_q) begin
      addr_q <= dec_q ? addr_q - AW'(1) : addr_q + AW'(1);
    end
  end

  // R5: a held address never moves on a step
  a_r5_hold_fixed: assert property (@(posedge clk) disable iff (rst)
    (step && hold_q && !load) |=> $stable(addr_q));
endmodule

// File: rtl/dma_m2m_seq.sv
module dma_m2m_seq
  import dma_m2m_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          start,
  input  logic [CW-1:0] cnt_init,
  input  logic [DW-1:0] rdata,
  output logic          load,
  output logic          src_step,
  output logic          dst_step,
  output logic          rd_q,
  output logic          wr_q,
  output logic          eop_q,
  output logic          busy,
  output logic [DW-1:0] temp_q
);
  seq_st_t       st;
  logic [CW-1:0] cnt_q;

  assign load     = (st == ST_IDLE) && start && en;
  assign src_step = (st == ST_CAP);
  assign dst_step = (st == ST_WR);
  assign busy     = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      rd_q   <= 1'b0;
      wr_q   <= 1'b0;
      eop_q  <= 1'b0;
      cnt_q  <= '0;
      temp_q <= '0;
    end else begin
      eop_q <= 1'b0;
      case (st)
        ST_IDLE: if (start && en) begin
          st    <= ST_RD;
          rd_q  <= 1'b1;
          cnt_q <= cnt_init;
        end
        ST_RD: begin
          st   <= ST_CAP;
          rd_q <= 1'b0;
        end
        ST_CAP: begin
          temp_q <= rdata;
          st     <= ST_WR;
          wr_q   <= 1'b1;
        end
        default: begin
          wr_q <= 1'b0;
          if (cnt_q == '0) begin
            st    <= ST_IDLE;
            eop_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q - CW'(1);
            st    <= ST_RD;
            rd_q  <= 1'b1;
          end
        end
      endcase
    end
  end

  a_r9_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    !(rd_q && wr_q));
  a_r3_wr_after_rd: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_q) |-> $past(rd_q, 2));
  a_r7_eop_single: assert property (@(posedge clk) disable iff (rst)
    eop_q |=> !eop_q);
  a_r7_eop_after_wr: assert property (@(posedge clk) disable iff (rst)
    eop_q |-> (!busy && $past(wr_q)));
  a_r1_disabled_no_rd: assert property (@(posedge clk) disable iff (rst)
    (!busy && !en) |=> !rd_q);
endmodule

// File: rtl/dma_m2m_engine.sv
module dma_m2m_engine #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          hold_src,
  input  logic          src_dir,
  input  logic          dst_dir,
  input  logic          start,
  input  logic [AW-1:0] src_base,
  input  logic [AW-1:0] dst_base,
  input  logic [CW-1:0] xfer_cnt,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          eop,
  output logic          busy,
  output logic [DW-1:0] temp_q
);
  logic          load, src_step, dst_step;
  logic [AW-1:0] src_addr, dst_addr;

  dma_m2m_seq #(.DW(DW), .CW(CW)) u_seq (
    .clk(clk), .rst(rst), .en(en), .start(start), .cnt_init(xfer_cnt),
    .rdata(mem_rdata), .load(load), .src_step(src_step), .dst_step(dst_step),
    .rd_q(mem_rd), .wr_q(mem_wr), .eop_q(eop), .busy(busy), .temp_q(temp_q)
  );

  dma_m2m_chan #(.AW(AW)) u_src (
    .clk(clk), .rst(rst), .load(load), .load_addr(src_base),
    .dir_in(src_dir), .hold_in(hold_src), .step(src_step), .addr_q(src_addr)
  );

  dma_m2m_chan #(.AW(AW)) u_dst (
    .clk(clk), .rst(rst), .load(load), .load_addr(dst_base),
    .dir_in(dst_dir), .hold_in(1'b0), .step(dst_step), .addr_q(dst_addr)
  );

  assign mem_addr  = mem_wr ? dst_addr : src_addr;
  assign mem_wdata = temp_q;
endmodule

// File: tb/dma_m2m_engine_test.sv
module dma_m2m_engine_test;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, hold_src = 1'b0, src_dir = 1'b0, dst_dir = 1'b0, start = 1'b0;
  logic [AW-1:0] src_base = '0, dst_base = '0, mem_addr;
  logic [CW-1:0] xfer_cnt = '0;
  logic mem_rd, mem_wr, eop, busy;
  logic [DW-1:0] mem_wdata, temp_q;
  logic [DW-1:0] mem_rdata = '0;

  always #2 clk = ~clk;

  dma_m2m_engine #(.AW(AW), .DW(DW), .CW(CW)) uut (
    .clk(clk), .rst(rst), .en(en), .hold_src(hold_src), .src_dir(src_dir),
    .dst_dir(dst_dir), .start(start), .src_base(src_base), .dst_base(dst_base),
    .xfer_cnt(xfer_cnt), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .eop(eop), .busy(busy),
    .temp_q(temp_q)
  );

  int total = 0;
  int bad = 0;
  logic [7:0] mem [256];
  logic [7:0] ref_mem [256];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bench memory: read data valid one clock after the read strobe
  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr];
    if (mem_wr) mem[mem_addr] <= mem_wdata;
  end

  // behavioural reference model
  int ph = 0;
  int s = 0, d = 0, n = 0;
  bit m_hold = 0, m_sd = 0, m_dd = 0, exp_eop = 0;
  int tmp = 0;
  always @(posedge clk) begin
    if (rst) begin
      ph = 0; tmp = 0; exp_eop = 0;
    end else begin
      exp_eop = 0;
      if (ph == 0) begin
        if (start && en) begin
          s = src_base; d = dst_base; n = xfer_cnt;
          m_hold = hold_src; m_sd = src_dir; m_dd = dst_dir; ph = 1;
        end
      end else if (ph == 1) ph = 2;
      else if (ph == 2) begin
        tmp = ref_mem[s]; ph = 3;
      end else begin
        ref_mem[d] = tmp[7:0];
        if (!m_hold) s = (m_sd ? s - 1 : s + 1) & 255;
        d = (m_dd ? d - 1 : d + 1) & 255;
        if (n == 0) begin ph = 0; exp_eop = 1; end
        else begin n = n - 1; ph = 1; end
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk(mem_rd == (ph == 1), "R3 rd", mem_rd, ph == 1);
      chk(mem_wr == (ph == 3), "R3 wr", mem_wr, ph == 3);
      chk(busy == (ph != 0), "R9 busy", busy, ph != 0);
      chk(eop == exp_eop, "R7 eop", eop, exp_eop);
      if (ph == 1) chk(mem_addr == s[7:0], "R4 src addr", mem_addr, s);
      if (ph == 3) begin
        chk(mem_addr == d[7:0], "R6 dst addr", mem_addr, d);
        chk(mem_wdata == tmp[7:0], "R3 wdata", mem_wdata, tmp);
      end
      if (ph == 0) chk(temp_q == tmp[7:0], "R8 temp", temp_q, tmp);
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic run(input int sb, input int db, input int cnt, input bit h,
                     input bit sd, input bit dd, input bit poke);
    int bytes;
    int eops;
    @(negedge clk);
    src_base = sb[7:0]; dst_base = db[7:0]; xfer_cnt = cnt[7:0];
    hold_src = h; src_dir = sd; dst_dir = dd; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R2: first read at source base right after start
    chk(mem_rd && mem_addr == sb[7:0], "R2 first read", mem_addr, sb);
    bytes = 0; eops = 0;
    while (ph != 0) begin
      if (mem_wr) bytes++;
      if (poke && bytes == 1) start = 1'b1; else start = 1'b0;
      @(negedge clk);
      if (eop) eops++;
    end
    start = 1'b0;
    chk(bytes == cnt + 1, "R7 byte count", bytes, cnt + 1);
    chk(eops == 1, "R7 eop count", eops, 1);
    for (int i = 0; i < 256; i++)
      if (mem[i] != ref_mem[i]) chk(0, "R6 memory", mem[i], ref_mem[i]);
    total++;
    if (h) for (int i = 0; i <= cnt; i++) begin
      int a = dd ? db - i : db + i;
      chk(mem[a & 255] == ref_mem[sb], "R5 fill", mem[a & 255], ref_mem[sb]);
    end
    repeat (3) @(negedge clk);
    chk(temp_q == tmp[7:0] && !busy, "R8 temp kept", temp_q, tmp);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'((i * 7 + 3) & 255);
      ref_mem[i] = 8'((i * 7 + 3) & 255);
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(!busy && !mem_rd && !mem_wr && !eop && temp_q == 0, "R10 reset", busy, 0);
    // R1: disabled start ignored
    @(negedge clk); start = 1'b1; src_base = 8'h10;
    @(negedge clk); start = 1'b0;
    repeat (4) begin
      chk(!busy && !mem_rd && !mem_wr, "R1 disabled", mem_rd, 0);
      @(negedge clk);
    end
    en = 1'b1;
    run(8'h10, 8'h80, 3, 0, 0, 0, 0);
    run(8'h2F, 8'hCF, 2, 0, 1, 1, 0);
    run(8'h05, 8'h40, 5, 1, 0, 0, 0);
    run(8'h60, 8'hA0, 0, 0, 0, 0, 0);
    run(8'h30, 8'hB0, 4, 0, 1, 0, 1);   // R9: start mid-transfer ignored
    run(8'h07, 8'hE8, 3, 1, 0, 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule